// File: doc/BRIEF.md
# Timer Channel Compare Output Stage

This block is the output stage of one timer channel. It takes the value of a shared up/down counter and a per-channel compare value, and derives from them a raw output level. A 3-bit mode code selects how that level is formed: one of two PWM shapes, a constant forced level, or holding the last level. The raw level then passes through a polarity inversion and an output enable before it reaches the pin. The counter period sets the PWM period and the compare value sets the duty cycle. Because the PWM level depends on the counting direction, the counter also supplies a direction bit.

Separately from the pin path, the block raises a sticky compare-match flag and a one-cycle DMA request whenever the counter equals the compare value. This happens in every mode, including the forced ones, where the pin ignores the compare. It also exports equal and greater-than compare results for a master-mode controller. The counter, dead-time insertion and break handling belong to other blocks.

Top module: `oc_pwm_channel`

## Requirements
- R1: The channel acts as an output only when `chan_sel` is not 2'b00. Otherwise `pin_out` is 0 and an equal compare neither sets `match_flag` nor pulses `dma_req`.
- R2: Mode 3'b110 (PWM A) produces a raw level of 1 when counting up (`cnt_down`=0) and `cnt_val` < `cmp_val`. When counting down (`cnt_down`=1), it produces 1 when `cnt_val` <= `cmp_val`. The raw level is 0 otherwise.
- R3: Mode 3'b111 (PWM B) produces the inverse of the PWM A level for the same counter value, compare value and direction.
- R4: Mode 3'b100 forces the raw level to 0 and mode 3'b101 forces it to 1, whatever the counter and compare values are.
- R5: Mode codes 3'b000 to 3'b011 keep the raw level at the value it last had.
- R6: When the channel is active, `pin_out` equals the raw level XOR `pol_inv` while `out_en`=1, and equals 0 while `out_en`=0. The raw level is registered on each clock edge.
- R7: `match_flag` becomes 1 after a clock edge at which `cnt_val` equals `cmp_val` on an active channel, in every mode including the forced ones. It then stays 1.
- R8: A `flag_clr` pulse clears `match_flag` at the next edge. An equal compare at that same edge wins over the clear.
- R9: `dma_req` is 1 for exactly the cycle after each edge at which an equal compare is seen on an active channel with `dma_en`=1, and is 0 otherwise.
- R10: `cmp_eq` and `cmp_gt` report `cnt_val` == `cmp_val` and `cnt_val` > `cmp_val`. They are combinational when `REG_CMP_OUT`=0 and delayed by one edge when it is 1.
- R11: While `rst_n` is 0, the raw level, `match_flag` and `dma_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_down | input | 1 | 1 while the counter counts down |
| cmp_val | input | CNT_W | Channel compare value (duty) |
| chan_sel | input | 2 | Channel direction select; non-zero means output |
| out_mode | input | 3 | Output mode code |
| pol_inv | input | 1 | Invert the raw level before the pin |
| out_en | input | 1 | Output enable |
| dma_en | input | 1 | Enable DMA request on match |
| flag_clr | input | 1 | Write-one clear of the match flag |
| pin_out | output | 1 | Channel pin level |
| match_flag | output | 1 | Sticky compare-match flag |
| dma_req | output | 1 | One-cycle DMA request |
| cmp_eq | output | 1 | Counter equals compare |
| cmp_gt | output | 1 | Counter greater than compare |

## Verification
The bench builds the block with `CNT_W`=8 and `REG_CMP_OUT`=0. With an 8-bit counter, the extreme values 0 and 255 can be driven directly, so the bench can check a zero duty, a full-scale compare and the equality point in both counting directions without long runs. With the combinational compare outputs, `cmp_eq` and `cmp_gt` can be checked in the same cycle as the counter value they describe.

// File: rtl/oc_pkg.sv
package oc_pkg;
   typedef enum logic [2:0] {
      OM_HOLD0    = 3'b000,
      OM_HOLD1    = 3'b001,
      OM_HOLD2    = 3'b010,
      OM_HOLD3    = 3'b011,
      OM_FORCE_LO = 3'b100,
      OM_FORCE_HI = 3'b101,
      OM_PWM_A    = 3'b110,
      OM_PWM_B    = 3'b111
   } out_mode_e;

   localparam logic [1:0] CHAN_SEL_OFF = 2'b00;
endpackage

// File: rtl/oc_compare.sv
module oc_compare #(
   parameter int W       = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic         eq_now_o,
   output logic         gt_now_o,
   output logic         eq_o,
   output logic         gt_o
);
   assign eq_now_o = (a_i == b_i);
   assign gt_now_o = (a_i > b_i);

   generate
      if (REG_OUT) begin : g_reg
         logic eq_q, gt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               eq_q <= 1'b0;
               gt_q <= 1'b0;
            end else begin
               eq_q <= eq_now_o;
               gt_q <= gt_now_o;
            end
         end
         assign eq_o = eq_q;
         assign gt_o = gt_q;
      end else begin : g_comb
         assign eq_o = eq_now_o;
         assign gt_o = gt_now_o;
      end
   endgenerate

   // R10: equal and greater-than never hold together
   a_r10_eq_gt_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(eq_o && gt_o));
endmodule

// File: rtl/oc_level_gen.sv
module oc_level_gen
   import oc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       active_i,
   input  logic [2:0] mode_i,
   input  logic       down_i,
   input  logic       eq_i,
   input  logic       gt_i,
   output logic       raw_o
);
   logic raw_q, raw_d, lvl_a;

   // PWM A: up -> below compare; down -> at or below compare
   assign lvl_a = down_i ? !gt_i : (!gt_i && !eq_i);

   always_comb begin
      raw_d = raw_q;
      if (active_i) begin
         case (out_mode_e'(mode_i))
            OM_PWM_A:    raw_d = lvl_a;
            OM_PWM_B:    raw_d = !lvl_a;
            OM_FORCE_LO: raw_d = 1'b0;
            OM_FORCE_HI: raw_d = 1'b1;
            default:     raw_d = raw_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) raw_q <= 1'b0;
      else        raw_q <= raw_d;
   end

   assign raw_o = raw_q;

   a_r4_force_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && mode_i == OM_FORCE_LO) |=> !raw_o);
   a_r4_force_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && mode_i == OM_FORCE_HI) |=> raw_o);
   a_r2_pwm_a_up_high: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && mode_i == OM_PWM_A && !down_i && gt_i) |=> !raw_o);
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (active_i && mode_i[2] == 1'b0) |=> $stable(raw_o));
endmodule

// File: rtl/oc_flag_unit.sv
module oc_flag_unit (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic clr_i,
   input  logic dma_en_i,
   output logic flag_o,
   output logic dma_o
);
   logic flag_q, dma_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         dma_q  <= 1'b0;
      end else begin
         if (hit_i)      flag_q <= 1'b1;
         else if (clr_i) flag_q <= 1'b0;
         dma_q <= hit_i && dma_en_i;
      end
   end

   assign flag_o = flag_q;
   assign dma_o  = dma_q;

   a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      hit_i |=> flag_o);
   a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !hit_i) |=> !flag_o);
   a_r9_dma_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i && dma_en_i) |=> dma_o);
   a_r9_dma_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_i && dma_en_i) |=> !dma_o);
endmodule

// File: rtl/oc_pwm_channel.sv
module oc_pwm_channel
   import oc_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter bit REG_CMP_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_down,
   input  logic [CNT_W-1:0] cmp_val,
   input  logic [1:0]       chan_sel,
   input  logic [2:0]       out_mode,
   input  logic             pol_inv,
   input  logic             out_en,
   input  logic             dma_en,
   input  logic             flag_clr,
   output logic             pin_out,
   output logic             match_flag,
   output logic             dma_req,
   output logic             cmp_eq,
   output logic             cmp_gt
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("oc_pwm_channel: CNT_W must lie in 2..32");
      end
   endgenerate

   logic active, eq_now, gt_now, raw;

   assign active = (chan_sel != CHAN_SEL_OFF);

   oc_compare #(.W(CNT_W), .REG_OUT(REG_CMP_OUT)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .a_i      (cnt_val),
      .b_i      (cmp_val),
      .eq_now_o (eq_now),
      .gt_now_o (gt_now),
      .eq_o     (cmp_eq),
      .gt_o     (cmp_gt)
   );

   oc_level_gen u_lvl (
      .clk      (clk),
      .rst_n    (rst_n),
      .active_i (active),
      .mode_i   (out_mode),
      .down_i   (cnt_down),
      .eq_i     (eq_now),
      .gt_i     (gt_now),
      .raw_o    (raw)
   );

   oc_flag_unit u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_i    (eq_now && active),
      .clr_i    (flag_clr),
      .dma_en_i (dma_en),
      .flag_o   (match_flag),
      .dma_o    (dma_req)
   );

   assign pin_out = (active && out_en) ? (raw ^ pol_inv) : 1'b0;

   // R1: an inactive channel raises no flag even on an equal compare
   a_r1_off_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !match_flag) |=> !match_flag);
   // R6: enable low keeps the pin at its inactive level
   a_r6_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> !pin_out);
endmodule

// File: tb/oc_pwm_channel_test.sv
module oc_pwm_channel_test;
   localparam int W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] cnt_val = '0, cmp_val = '0;
   logic cnt_down = 1'b0;
   logic [1:0] chan_sel = 2'b01;
   logic [2:0] out_mode = 3'b000;
   logic pol_inv = 1'b0, out_en = 1'b1, dma_en = 1'b0, flag_clr = 1'b0;
   logic pin_out, match_flag, dma_req, cmp_eq, cmp_gt;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;   // 125 MHz

   oc_pwm_channel #(.CNT_W(W), .REG_CMP_OUT(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
      .cmp_val(cmp_val), .chan_sel(chan_sel), .out_mode(out_mode),
      .pol_inv(pol_inv), .out_en(out_en), .dma_en(dma_en),
      .flag_clr(flag_clr), .pin_out(pin_out), .match_flag(match_flag),
      .dma_req(dma_req), .cmp_eq(cmp_eq), .cmp_gt(cmp_gt)
   );

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step;
      @(posedge clk);
      @(negedge clk);
   endtask

   // {mode[2:0], down, cnt[7:0], cmp[7:0], pol, en, expected_pin}
   localparam int NV = 16;
   localparam logic [22:0] VEC [NV] = '{
      {3'b110, 1'b0, 8'd3,   8'd5,   1'b0, 1'b1, 1'b1},  // R2 up below
      {3'b110, 1'b0, 8'd5,   8'd5,   1'b0, 1'b1, 1'b0},  // R2 up equal
      {3'b110, 1'b0, 8'd7,   8'd5,   1'b0, 1'b1, 1'b0},  // R2 up above
      {3'b110, 1'b1, 8'd5,   8'd5,   1'b0, 1'b1, 1'b1},  // R2 down equal
      {3'b110, 1'b1, 8'd6,   8'd5,   1'b0, 1'b1, 1'b0},  // R2 down above
      {3'b110, 1'b0, 8'd0,   8'd0,   1'b0, 1'b1, 1'b0},  // R2 zero duty
      {3'b110, 1'b0, 8'd254, 8'd255, 1'b0, 1'b1, 1'b1},  // R2 full scale
      {3'b111, 1'b0, 8'd3,   8'd5,   1'b0, 1'b1, 1'b0},  // R3 up below
      {3'b111, 1'b0, 8'd5,   8'd5,   1'b0, 1'b1, 1'b1},  // R3 up equal
      {3'b111, 1'b1, 8'd5,   8'd5,   1'b0, 1'b1, 1'b0},  // R3 down equal
      {3'b100, 1'b0, 8'd3,   8'd5,   1'b0, 1'b1, 1'b0},  // R4 force low
      {3'b101, 1'b0, 8'd7,   8'd5,   1'b0, 1'b1, 1'b1},  // R4 force high
      {3'b101, 1'b0, 8'd7,   8'd5,   1'b1, 1'b1, 1'b0},  // R6 polarity
      {3'b110, 1'b0, 8'd3,   8'd5,   1'b1, 1'b1, 1'b0},  // R6 polarity pwm
      {3'b110, 1'b0, 8'd3,   8'd5,   1'b0, 1'b0, 1'b0},  // R6 disabled
      {3'b111, 1'b1, 8'd255, 8'd255, 1'b0, 1'b1, 1'b0}   // R3 down top
   };

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R11: reset state
      repeat (3) @(negedge clk);
      check("R11 flag", match_flag, 1'b0);
      check("R11 dma", dma_req, 1'b0);
      check("R11 pin", pin_out, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         {out_mode, cnt_down, cnt_val, cmp_val, pol_inv, out_en} = VEC[i][22:1];
         step();
         check($sformatf("R2/R3/R4/R6 vec%0d", i), pin_out, VEC[i][0]);
      end
      pol_inv = 1'b0; out_en = 1'b1;

      // R10: compare outputs, same cycle
      cnt_val = 8'd6; cmp_val = 8'd5; #1;
      check("R10 gt", cmp_gt, 1'b1);
      check("R10 eq", cmp_eq, 1'b0);
      cnt_val = 8'd5; #1;
      check("R10 eq", cmp_eq, 1'b1);
      check("R10 gt", cmp_gt, 1'b0);

      // clear the flag left by the vectors
      cnt_val = 8'd1; flag_clr = 1'b1; step(); flag_clr = 1'b0;
      check("R8 clear", match_flag, 1'b0);

      // R7/R9: forced mode still flags and requests DMA
      out_mode = 3'b100; dma_en = 1'b1; cnt_val = 8'd9; cmp_val = 8'd9;
      step();
      check("R7 flag in forced", match_flag, 1'b1);
      check("R9 dma pulse", dma_req, 1'b1);
      check("R4 pin forced low", pin_out, 1'b0);
      cnt_val = 8'd10; step();
      check("R9 dma one cycle", dma_req, 1'b0);
      check("R7 sticky", match_flag, 1'b1);
      flag_clr = 1'b1; step(); flag_clr = 1'b0;
      check("R8 clear", match_flag, 1'b0);

      // R8: set wins over clear
      cnt_val = 8'd9; flag_clr = 1'b1; step(); flag_clr = 1'b0;
      check("R8 set wins", match_flag, 1'b1);
      dma_en = 1'b0; step();
      check("R9 dma disabled", dma_req, 1'b0);
      cnt_val = 8'd1; flag_clr = 1'b1; step(); flag_clr = 1'b0;

      // R1: inactive channel
      out_mode = 3'b101; step();
      check("R1 pin active first", pin_out, 1'b1);
      chan_sel = 2'b00; dma_en = 1'b1; cnt_val = 8'd9; step();
      check("R1 pin off", pin_out, 1'b0);
      check("R1 no flag", match_flag, 1'b0);
      check("R1 no dma", dma_req, 1'b0);

      // R5: hold codes keep the raw level
      chan_sel = 2'b10; dma_en = 1'b0; cnt_val = 8'd1; step();
      check("R5 prior high", pin_out, 1'b1);
      for (int m = 0; m < 4; m++) begin
         out_mode = m[2:0]; cnt_val = 8'd200; cmp_val = 8'd100; step();
         check($sformatf("R5 hold code %0d", m), pin_out, 1'b1);
      end
      out_mode = 3'b100; step();
      out_mode = 3'b011; cnt_val = 8'd0; step();
      check("R5 hold low", pin_out, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule